// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial bus, placed in front of a small byte-wide memory held in registers. It works from a fast system clock. It receives the bus clock and data lines as plain inputs and filters each one digitally. It pulls the data line low through an open-drain enable output. The block recognises Start and Stop conditions and decodes a control byte that carries a fixed family code, three strap bits and a direction bit. It acknowledges each accepted byte, stores written bytes and returns memory bytes to the master on reads.

A write transfer carries a control byte, two address bytes with the most significant byte first, and then any number of data bytes. A Stop that closes a write containing data starts a programming interval. The length of that interval is set by a parameter. While it runs, the block ignores the bus completely. A write-protect input prevents the memory from being changed but leaves reads working. A read continues from the current address, and a repeated Start placed after the address bytes turns a write into a random read. The data line changes only while the clock is low, and only after a fixed hold delay following each clock fall.

Top module: `eeprom_slave`

## Requirements
- R1: A falling data line while the filtered clock is high is a Start. A Start aborts any transfer in progress, including a partly received byte, and the next 8 bits are taken as a control byte. A rising data line while the clock is high is a Stop, and it returns the block to idle.
- R2: The control byte, sent MSB first, is 4'b1010, then the three strap bits (strap_i[2] first), then the direction bit (1 = read). On a match, the block holds the data line low through the whole high period of the ninth clock. On a mismatch, the block gives no acknowledge and stays released until the next Start.
- R3: A write control byte is followed by two address bytes. The first address byte supplies word-address bits 13:8 and its top two bits are ignored. The block acknowledges each data byte that follows, stores it at the current address and then increments the address. The memory index is the address modulo MEM_WORDS, so the address wraps.
- R4: A Stop that ends a write containing at least one stored data byte starts a busy interval of BUSY_CYC system clocks. A write that ends after its address bytes starts no busy interval.
- R5: During the busy interval, the block acknowledges no byte, including a matching control byte.
- R6: While wp_i is high, data bytes are still acknowledged, but memory keeps its old contents and no busy interval starts.
- R7: After a read control byte, the block sends the byte at the current address, MSB first, and then increments the address. Each acknowledge from the master leads to the next byte. A repeated Start after the two address bytes, followed by a read control byte, reads from the address just written.
- R8: When the master does not acknowledge a read byte, the block releases the data line and keeps it released until the next Start.
- R9: A pulse on scl_i or sda_i that lasts fewer than FILT_CYC system clocks has no effect.
- R10: sda_oe_o never changes while the filtered clock is high. It changes only after the clock has been low for HOLD_CYC system clocks.
- R11: After reset, sda_oe_o is low, the block is not busy, the address is 0 and every memory byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (the wired level) |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Write protect, high blocks memory updates |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The main function is exercised with several kinds of transfer:
- Matching and mismatching control bytes separate address decode from acknowledge generation.
- A three-byte write followed by a random read with master acknowledges and a final no-acknowledge shows storage, address increment and release after the last byte.
- A current-address read shows that the address carries over from one transfer to the next.
- An address-only write, a protected write and a write that is attempted during the busy interval separate the three conditions that govern programming.
- A write whose address crosses the top of memory shows the wrap.
- A byte carrying short clock and data pulses shows the filter.
- A Start inside a byte shows the abort.
- Sampling the data enable just before and just after the hold delay following a clock fall shows the output timing.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    localparam logic [3:0] CTRL_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADRH,
        ST_ADRL,
        ST_WDAT,
        ST_RDAT
    } st_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int FILT_CYC = 10,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic y_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          y;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        f_d.sync = {f_q.sync[0], d_i};
        if (f_q.sync[1] != f_q.y) begin
            if (f_q.cnt == CW'(FILT_CYC - 1)) begin
                f_d.y   = f_q.sync[1];
                f_d.cnt = '0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end else begin
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.sync <= {2{IDLE_LVL}};
            f_q.cnt  <= '0;
            f_q.y    <= IDLE_LVL;
        end else begin
            f_q <= f_d;
        end
    end

    assign y_o = f_q.y;

    // R9: the output moves only once the input has differed for the full window
    assert_filter_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q.y) |-> ($past(f_q.cnt) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int BUSY_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R4: a programming request makes the block busy on the next cycle
    assert_busy_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R4: the busy interval drains one cycle at a time
    assert_busy_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int ADDR_W    = 14,
    parameter int FILT_CYC  = 10,
    parameter int HOLD_CYC  = 60,
    parameter int BUSY_CYC  = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int IW = $clog2(MEM_WORDS);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        st_e               st;
        st_e               nst;
        logic [3:0]        bits;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic              ack;
        logic              mack;
        logic              wrote;
        logic              drv;
        logic              scl_p;
        logic              sda_p;
        logic              oe;
        logic [HW-1:0]     hc;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0] mem_q [MEM_WORDS];
    logic       scl_f, sda_f, prog_go, prog_busy, mem_we;
    logic       scl_rise, scl_fall, start_ev, stop_ev, ctrl_hit;
    logic [7:0] rd_byte;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_flt
            logic fo;
            line_filter #(.FILT_CYC(FILT_CYC), .IDLE_LVL(1'b1)) u_flt (
                .clk(clk), .rst_n(rst_n),
                .d_i((g == 0) ? scl_i : sda_i),
                .y_o(fo)
            );
        end
    endgenerate

    assign scl_f = g_flt[0].fo;
    assign sda_f = g_flt[1].fo;

    prog_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(prog_go), .busy_o(prog_busy)
    );

    assign scl_rise = scl_f & ~r_q.scl_p;
    assign scl_fall = ~scl_f & r_q.scl_p;
    assign start_ev = scl_f & r_q.scl_p & r_q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & r_q.scl_p & ~r_q.sda_p & sda_f;
    assign ctrl_hit = (r_q.sh[7:1] == {CTRL_TAG, strap_i});
    assign rd_byte  = mem_q[r_q.addr[IW-1:0]];

    always_comb begin
        r_d     = r_q;
        mem_we  = 1'b0;
        prog_go = 1'b0;
        r_d.scl_p = scl_f;
        r_d.sda_p = sda_f;
        if (start_ev) begin
            r_d.st    = ST_CTRL;
            r_d.bits  = 4'd0;
            r_d.ack   = 1'b0;
            r_d.wrote = 1'b0;
        end else if (stop_ev) begin
            prog_go   = r_q.wrote;
            r_d.st    = ST_IDLE;
            r_d.ack   = 1'b0;
            r_d.wrote = 1'b0;
        end else if (r_q.st == ST_RDAT) begin
            if (scl_rise && r_q.bits <= 4'd8) begin
                if (r_q.bits == 4'd8) r_d.mack = ~sda_f;
                r_d.bits = r_q.bits + 1'b1;
            end
            if (scl_fall) begin
                if (r_q.bits < 4'd8) begin
                    r_d.sh = {r_q.sh[6:0], 1'b0};
                end else if (r_q.bits == 4'd9) begin
                    if (r_q.mack) begin
                        r_d.sh   = rd_byte;
                        r_d.addr = r_q.addr + ADDR_W'(1);
                        r_d.bits = 4'd0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
        end else if (r_q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (r_q.bits < 4'd8) begin
                    r_d.sh   = {r_q.sh[6:0], sda_f};
                    r_d.bits = r_q.bits + 1'b1;
                end else if (r_q.bits == 4'd8) begin
                    r_d.bits = 4'd9;
                end
            end
            if (scl_fall && r_q.bits == 4'd8) begin
                r_d.ack = 1'b1;
                unique case (r_q.st)
                    ST_CTRL: begin
                        if (ctrl_hit && !prog_busy) begin
                            r_d.nst = r_q.sh[0] ? ST_RDAT : ST_ADRH;
                        end else begin
                            r_d.ack = 1'b0;
                            r_d.st  = ST_IDLE;
                        end
                    end
                    ST_ADRH: begin
                        r_d.addr[ADDR_W-1:8] = r_q.sh[ADDR_W-9:0];
                        r_d.nst = ST_ADRL;
                    end
                    ST_ADRL: begin
                        r_d.addr[7:0] = r_q.sh;
                        r_d.nst = ST_WDAT;
                    end
                    default: begin
                        mem_we    = ~wp_i;
                        r_d.wrote = r_q.wrote | ~wp_i;
                        r_d.addr  = r_q.addr + ADDR_W'(1);
                        r_d.nst   = ST_WDAT;
                    end
                endcase
            end else if (scl_fall && r_q.bits == 4'd9) begin
                r_d.ack  = 1'b0;
                r_d.bits = 4'd0;
                r_d.st   = r_q.nst;
                if (r_q.nst == ST_RDAT) begin
                    r_d.sh   = rd_byte;
                    r_d.addr = r_q.addr + ADDR_W'(1);
                end
            end
        end
        r_d.drv = r_d.ack | ((r_d.st == ST_RDAT) && (r_d.bits < 4'd8) && !r_d.sh[7]);
        if (scl_fall)
            r_d.hc = HW'(HOLD_CYC);
        else if (r_q.hc != '0)
            r_d.hc = r_q.hc - 1'b1;
        if (!scl_f && !scl_fall && r_q.hc == '0)
            r_d.oe = r_q.drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.nst   <= ST_IDLE;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= 8'h00;
        end else if (mem_we) begin
            mem_q[r_q.addr[IW-1:0]] <= r_q.sh;
        end
    end

    assign sda_oe_o = r_q.oe;

    // checker-side count of how long the filtered clock has been low
    logic [HW-1:0] low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_q <= '0;
        else if (scl_f)                 low_q <= '0;
        else if (low_q != HW'(HOLD_CYC)) low_q <= low_q + 1'b1;
    end

    // R10: the data enable moves only after the hold delay within a low phase
    assert_oe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> ($past(low_q) == HW'(HOLD_CYC)));
    // R5: no acknowledge is armed for a control byte while busy
    assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && r_q.st == ST_CTRL) |-> !r_q.ack);
    // R6: write protect keeps the memory port quiet
    assert_wp_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we);
    // R8: an idle block never wants the data line low
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !r_q.drv);
endmodule

// File: tb/eeprom_slave_test.sv
module eeprom_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       oe;
    logic       line;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    localparam int BUSY = 8000;
    localparam logic [7:0] WR = 8'hAA;
    localparam logic [7:0] RD = 8'hAB;

    assign line = ~(m_low | oe);

    always #2.5 clk = ~clk;

    eeprom_slave #(.MEM_WORDS(64), .ADDR_W(14), .FILT_CYC(10),
                   .HOLD_CYC(40), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
        .strap_i(strap), .wp_i(wp), .sda_oe_o(oe)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(80); scl = 1'b1; wt(80);
        m_low = 1'b1; wt(80); scl = 1'b0; wt(80);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(80); scl = 1'b1; wt(80); m_low = 1'b0; wt(80);
    endtask

    task automatic wbit(input bit b);
        m_low = ~b; wt(80); scl = 1'b1; wt(80); scl = 1'b0; wt(80);
    endtask

    task automatic rbit(output bit b);
        m_low = 1'b0; wt(80); scl = 1'b1; wt(40); b = line;
        wt(40); scl = 1'b0; wt(80);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~mack);
    endtask

    task automatic wbyte_glitch(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) begin
                m_low = ~v[i]; wt(30);
                scl = 1'b1; wt(5); scl = 1'b0; wt(45);
                scl = 1'b1; wt(30);
                m_low = ~m_low; wt(5); m_low = ~m_low; wt(45);
                scl = 1'b0; wt(80);
            end else begin
                wbit(v[i]);
            end
        end
        rbit(a);
        ack = ~a;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        bit a;
        bus_start();
        wbyte(WR, a); chk({req, " control ack"}, a, 1);
        wbyte(hi, a); chk({req, " address high ack"}, a, 1);
        wbyte(lo, a); chk({req, " address low ack"}, a, 1);
    endtask

    task automatic t_reset();
        bit a;
        logic [7:0] v;
        chk("R11 enable low after reset", oe, 0);
        bus_start();
        wbyte(RD, a); chk("R11 read control ack", a, 1);
        rbyte(1'b0, v); chk("R11 byte at address 0 is clear", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit a;
        bus_start();
        wbyte(8'hA9, a); chk("R2 strap mismatch no ack", a, 0);
        wbyte(8'h00, a); chk("R2 silent until next start", a, 0);
        bus_stop();
        bus_start();
        wbyte(8'h2B, a); chk("R2 family mismatch no ack", a, 0);
        bus_stop();
    endtask

    task automatic t_ack_timing();
        bit a;
        bus_start();
        for (int i = 7; i >= 0; i--) wbit(WR[i]);
        m_low = 1'b0; wt(80); scl = 1'b1; wt(40);
        chk("R2 line low in ack high phase", line, 0);
        wt(40); scl = 1'b0; wt(20);
        chk("R10 ack held just after clock fall", oe, 1);
        wt(50);
        chk("R10 ack released after hold delay", oe, 0);
        wt(10);
        wbyte(8'h00, a); chk("R4 address high ack", a, 1);
        wbyte(8'h05, a); chk("R4 address low ack", a, 1);
        bus_stop();
        bus_start();
        wbyte(WR, a); chk("R4 no busy after address-only write", a, 1);
        bus_stop();
    endtask

    task automatic t_write_read();
        bit a;
        logic [7:0] v;
        set_addr(8'h00, 8'h10, "R3");
        wbyte(8'h5A, a); chk("R3 data0 ack", a, 1);
        wbyte(8'hC3, a); chk("R3 data1 ack", a, 1);
        wbyte(8'h0F, a); chk("R3 data2 ack", a, 1);
        bus_stop();
        bus_start();
        wbyte(WR, a); chk("R5 no ack while busy", a, 0);
        bus_stop();
        wt(BUSY);
        set_addr(8'h00, 8'h10, "R7");
        bus_start();
        wbyte(RD, a); chk("R7 random read control ack", a, 1);
        rbyte(1'b1, v); chk("R7 first byte", v, 8'h5A);
        rbyte(1'b1, v); chk("R7 second byte", v, 8'h C3);
        rbyte(1'b0, v); chk("R7 third byte", v, 8'h0F);
        rbit(a); chk("R8 line released after nack", a, 1);
        chk("R8 enable low after nack", oe, 0);
        bus_stop();
        bus_start();
        wbyte(RD, a); chk("R7 current read ack", a, 1);
        rbyte(1'b0, v); chk("R7 current address continues", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_protect();
        bit a;
        logic [7:0] v;
        wp = 1'b1;
        set_addr(8'h00, 8'h10, "R6");
        wbyte(8'hEE, a); chk("R6 protected data still acked", a, 1);
        bus_stop();
        set_addr(8'h00, 8'h10, "R6 no busy");
        bus_start();
        wbyte(RD, a); chk("R6 read control ack", a, 1);
        rbyte(1'b0, v); chk("R6 memory unchanged", v, 8'h5A);
        bus_stop();
        wp = 1'b0;
    endtask

    task automatic t_glitch();
        bit a;
        logic [7:0] v;
        bus_start();
        wbyte(WR, a); chk("R9 control ack", a, 1);
        wbyte(8'h00, a); chk("R9 address high ack", a, 1);
        wbyte_glitch(8'h20, a); chk("R9 glitched byte ack", a, 1);
        wbyte(8'h96, a); chk("R9 data ack", a, 1);
        bus_stop();
        wt(BUSY);
        set_addr(8'h00, 8'h20, "R9 readback");
        bus_start();
        wbyte(RD, a);
        rbyte(1'b0, v); chk("R9 pulses ignored", v, 8'h96);
        bus_stop();
    endtask

    task automatic t_restart();
        bit a;
        logic [7:0] v;
        bus_start();
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        bus_start();
        wbyte(RD, a); chk("R1 start inside byte restarts", a, 1);
        rbyte(1'b0, v); chk("R1 read after restart", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit a;
        logic [7:0] v;
        set_addr(8'hFF, 8'hFF, "R3 wrap");
        wbyte(8'h11, a); chk("R3 last word ack", a, 1);
        wbyte(8'h22, a); chk("R3 wrapped word ack", a, 1);
        bus_stop();
        wt(BUSY);
        set_addr(8'h00, 8'h3F, "R7 wrap");
        bus_start();
        wbyte(RD, a);
        rbyte(1'b1, v); chk("R7 top word", v, 8'h11);
        rbyte(1'b0, v); chk("R7 read wraps to word 0", v, 8'h22);
        bus_stop();
    endtask

    initial begin
        wt(10);
        chk("R11 enable low in reset", oe, 0);
        rst_n = 1'b1;
        wt(20);
        t_reset();
        t_mismatch();
        t_ack_timing();
        t_write_read();
        t_protect();
        t_glitch();
        t_restart();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule